// File: doc/BRIEF.md
# Convolutional Byte De-interleaver

This block undoes a byte-wise convolutional interleaver on a stream of 204-byte coded packets. Accepted bytes are dealt in turn to twelve branches. Each branch is a delay line that advances only when the commutator visits it. Branch j holds a byte for (11 - j) x 17 visits, so branch 0 has the longest delay and branch 11 passes its byte straight through. The input carries a valid strobe and a start flag that upstream logic has already aligned to the packet sync byte. The output gives the bytes back in their original order, together with a freshly generated start flag.

The stage sits between byte/packet synchronisation and the block decoder. Its output stays quiet until every delay line holds real data. A start flag that arrives while the commutator is not on branch 0 is taken as a loss of alignment: the commutator snaps back to branch 0 and filling starts over.

Top module: `deil_top`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `out_valid` and `out_sop` are 0.
- R2: Each accepted byte (`in_valid` = 1) goes to the current branch, and the commutator then moves to the next branch, wrapping from branch 11 to branch 0. A byte with `in_sop` = 1 goes to branch 0, and the commutator moves on to branch 1.
- R3: Branch j returns the byte written to it (11 - j) x 17 visits earlier. As a result, output byte s after filling equals original byte s - 2244 of the stream that was interleaved.
- R4: Count the accepted bytes from reset or from the last restart. `out_valid` is 1 exactly in the cycle after an accepted byte whose index is 2244 or more, and is 0 in every other cycle.
- R5: An `in_sop` on a byte that arrives while the commutator is already on branch 0 does not restart filling, and the output keeps flowing.
- R6: An `in_sop` on a byte that arrives while the commutator is on any branch other than 0 is a restart. That byte becomes index 0, and `out_valid` stays 0 for the next 2244 accepted bytes.
- R7: `out_sop` is 1 on the first valid output after filling and on every 204th valid output after that. It always marks a byte that came from branch 0.
- R8: When `in_valid` = 0, the values on `in_data` and `in_sop` have no effect. The commutator, the fill count and the delay lines hold, and `out_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_sop | input | 1 | Input byte is a packet sync byte |
| in_data | input | 8 | Interleaved input byte |
| out_valid | output | 1 | De-interleaved byte is present |
| out_sop | output | 1 | Output byte starts a 204-byte packet |
| out_data | output | 8 | De-interleaved byte, 0 when not valid |

## Verification
Assertions check the commutator's step and wrap on every cycle. They also check that the commutator and the fill count hold when no byte is accepted, that the fill count stays in range, that each delay-line pointer stays within its depth, and that every output start flag lands on a branch-0 byte. Only the bench scenarios can show that the twelve delay lines really restore the original byte order, and that filling produces exactly 2244 silent bytes. They also show that aligned sync flags leave the stream running, and that a misaligned flag restarts it. The bench does this by feeding an arithmetically interleaved stream, with idle gaps that carry junk data and junk start flags.

// File: rtl/deil_pkg.sv
package deil_pkg;

    localparam int BYTE_W       = 8;
    localparam int BRANCHES_DEF = 12;
    localparam int UNIT_DEF     = 17;

    // Delay, in branch visits, of branch j of the de-interleaver.
    function automatic int branch_depth(input int j, input int branches, input int unit);
        return (branches - 1 - j) * unit;
    endfunction

    // Pointer width for a delay line of the given depth.
    function automatic int ptr_width(input int depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction

    // Byte as it enters the block.
    typedef struct packed {
        logic              sop;
        logic [BYTE_W-1:0] data;
    } deil_beat_t;

    // Control word carried one stage behind the commutator.
    typedef struct packed {
        logic vld;
        logic filled;
        logic restart;
    } deil_ctrl_t;

endpackage

// File: rtl/deil_branch_fifo.sv
module deil_branch_fifo #(
    parameter int DEPTH = 17,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    import deil_pkg::*;

    generate
        if (DEPTH == 0) begin : g_pass
            // Zero-delay branch: the byte is only registered.
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (en)
                    q <= din;
            end
        end else begin : g_line
            localparam int PTR_W = ptr_width(DEPTH);

            logic [W-1:0]     mem [DEPTH];
            logic [PTR_W-1:0] ptr;

            always_ff @(posedge clk) begin
                if (rst)
                    ptr <= '0;
                else if (en)
                    ptr <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
            end

            // Read the oldest entry and replace it in the same visit.
            always_ff @(posedge clk) begin
                if (en) begin
                    q        <= mem[ptr];
                    mem[ptr] <= din;
                end
            end

            assert_ptr_range_R3: assert property (@(posedge clk) disable iff (rst)
                int'(ptr) < DEPTH);
            assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
                !en |=> $stable(ptr));
        end
    endgenerate

endmodule

// File: rtl/deil_commutator.sv
module deil_commutator #(
    parameter int BRANCHES = 12,
    parameter int FILL     = 2244,
    parameter int SEL_W    = 4,
    parameter int FILL_W   = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sop,
    output logic [SEL_W-1:0] sel,
    output logic             filled,
    output logic             restart
);
    logic [SEL_W-1:0]  br;
    logic [FILL_W-1:0] cnt;

    always_comb begin
        restart = in_valid && in_sop && (br != '0);
        sel     = in_sop ? '0 : br;
        filled  = !restart && (cnt == FILL_W'(FILL));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            br  <= '0;
            cnt <= '0;
        end else if (in_valid) begin
            br <= (sel == SEL_W'(BRANCHES - 1)) ? '0 : sel + 1'b1;
            if (restart)
                cnt <= FILL_W'(1);
            else if (cnt != FILL_W'(FILL))
                cnt <= cnt + 1'b1;
        end
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_sop && br == SEL_W'(BRANCHES - 1) |=> br == '0);
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_sop && br != SEL_W'(BRANCHES - 1) |=> br == $past(br) + 1'b1);
    assert_sync_branch_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_sop |=> br == SEL_W'(1));
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(br) && $stable(cnt));
    assert_fill_range_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= FILL_W'(FILL));

endmodule

// File: rtl/deil_framer.sv
module deil_framer #(
    parameter int PKT_LEN = 204,
    parameter int POS_W   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic vld,
    input  logic restart,
    output logic sop
);
    logic [POS_W-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst || restart)
            pos <= '0;
        else if (vld)
            pos <= (pos == POS_W'(PKT_LEN - 1)) ? '0 : pos + 1'b1;
    end

    assign sop = vld && (pos == '0);

    assert_pos_range_R7: assert property (@(posedge clk) disable iff (rst)
        int'(pos) < PKT_LEN);
    assert_pos_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        vld && !restart && pos == POS_W'(PKT_LEN - 1) |=> pos == '0);

endmodule

// File: rtl/deil_top.sv
module deil_top #(
    parameter int BRANCHES = deil_pkg::BRANCHES_DEF,
    parameter int UNIT     = deil_pkg::UNIT_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic                        in_sop,
    input  logic [deil_pkg::BYTE_W-1:0] in_data,
    output logic                        out_valid,
    output logic                        out_sop,
    output logic [deil_pkg::BYTE_W-1:0] out_data
);
    import deil_pkg::*;

    localparam int PKT_LEN = BRANCHES * UNIT;
    localparam int FILL    = (BRANCHES - 1) * UNIT * BRANCHES;
    localparam int SEL_W   = $clog2(BRANCHES);
    localparam int FILL_W  = $clog2(FILL + 1);
    localparam int POS_W   = $clog2(PKT_LEN);

    deil_beat_t        beat;
    logic [SEL_W-1:0]  sel;
    logic [SEL_W-1:0]  sel_d;
    logic              filled;
    logic              restart;
    deil_ctrl_t        ctrl_d;
    logic [BRANCHES-1:0] en;
    logic [BYTE_W-1:0] q_arr [BRANCHES];
    logic              stage_vld;

    assign beat = '{sop: in_sop, data: in_data};

    deil_commutator #(
        .BRANCHES (BRANCHES),
        .FILL     (FILL),
        .SEL_W    (SEL_W),
        .FILL_W   (FILL_W)
    ) i_comm (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sop   (beat.sop),
        .sel      (sel),
        .filled   (filled),
        .restart  (restart)
    );

    genvar j;
    generate
        for (j = 0; j < BRANCHES; j++) begin : g_branch
            assign en[j] = in_valid && (sel == SEL_W'(j));

            deil_branch_fifo #(
                .DEPTH (branch_depth(j, BRANCHES, UNIT)),
                .W     (BYTE_W)
            ) i_fifo (
                .clk (clk),
                .rst (rst),
                .en  (en[j]),
                .din (beat.data),
                .q   (q_arr[j])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_d <= '0;
            sel_d  <= '0;
        end else begin
            ctrl_d <= '{vld: in_valid, filled: filled, restart: restart};
            if (in_valid)
                sel_d <= sel;
        end
    end

    assign stage_vld = ctrl_d.vld && ctrl_d.filled;

    deil_framer #(
        .PKT_LEN (PKT_LEN),
        .POS_W   (POS_W)
    ) i_framer (
        .clk     (clk),
        .rst     (rst),
        .vld     (stage_vld),
        .restart (ctrl_d.restart),
        .sop     (out_sop)
    );

    assign out_valid = stage_vld;
    assign out_data  = stage_vld ? q_arr[sel_d] : '0;

    assert_sop_on_branch0_R7: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> sel_d == '0);
    assert_valid_follows_input_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));
    assert_onehot_enable_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(en));

endmodule

// File: tb/test_deil_top.sv
`timescale 1ns/1ps
module test_deil_top;

    localparam int B    = 12;
    localparam int M    = 17;
    localparam int PKT  = B * M;
    localparam int FILL = (B - 1) * M * B;
    localparam int L1   = FILL + 4 * PKT + 7;
    localparam int L2   = FILL + 3 * PKT;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sop = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_valid;
    logic       out_sop;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    int drv_idx = 0;
    int prev_idx = 0;
    logic prev_v = 1'b0;
    int phase = 0;
    bit mon_on = 1'b0;
    int nvalid = 0;

    always #4 clk = ~clk;

    deil_top i_deil_top (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_data  (out_data)
    );

    function automatic logic [7:0] orig(input int k);
        if (k % PKT == 0) return 8'h47;
        return 8'((k * 13) + (k / PKT) * 5 + 1);
    endfunction

    // Interleaved stream: step t on branch t%B carries original byte t - (t%B)*PKT.
    function automatic logic [7:0] il(input int t);
        int src;
        src = t - (t % B) * PKT;
        if (src < 0) return 8'(t ^ 8'h5A);
        return orig(src);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input int t);
        @(negedge clk);
        in_valid = 1'b1;
        in_sop   = (t % PKT == 0);
        in_data  = il(t);
        drv_idx  = t;
    endtask

    // Idle cycle with junk on data and start flag (R8).
    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b1;
        in_data  = 8'hFF;
    endtask

    always @(posedge clk) begin
        prev_v   <= in_valid;
        prev_idx <= drv_idx;
    end

    always @(negedge clk) begin
        if (mon_on) begin
            bit exp_ov;
            exp_ov = prev_v && (prev_idx >= FILL);
            if (!prev_v)
                chk(out_valid == exp_ov, "R8 idle cycle out_valid", int'(out_valid), int'(exp_ov));
            else if (phase == 2)
                chk(out_valid == exp_ov, "R6 out_valid after restart", int'(out_valid), int'(exp_ov));
            else
                chk(out_valid == exp_ov, "R4 out_valid fill gating", int'(out_valid), int'(exp_ov));
            if (exp_ov && out_valid) begin
                int k;
                k = prev_idx - FILL;
                nvalid++;
                // R2 commutation order and R3 branch delays together restore byte k.
                chk(out_data == orig(k), "R3 data order", int'(out_data), int'(orig(k)));
                chk(out_sop == (k % PKT == 0), "R7 output start flag",
                    int'(out_sop), int'(k % PKT == 0));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(out_sop == 1'b0, "R1 out_sop in reset", int'(out_sop), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(out_sop == 1'b0, "R1 out_sop after reset", int'(out_sop), 0);
        mon_on = 1'b1;

        // Phase 1: aligned stream with idle gaps.
        phase = 1;
        for (int t = 0; t < L1; t++) begin
            drive(t);
            if (t % 9 == 8) idle();
        end
        idle(); idle(); idle();
        // R5: aligned sync bytes never restarted filling.
        chk(nvalid == L1 - FILL, "R5 outputs of aligned stream", nvalid, L1 - FILL);

        // Phase 2: L1 % B = 7, so the first sync byte here is misaligned.
        phase = 2;
        nvalid = 0;
        for (int t = 0; t < L2; t++) begin
            drive(t);
            if (t % 7 == 3) idle();
        end
        idle(); idle(); idle();
        chk(nvalid == L2 - FILL, "R6 outputs after restart", nvalid, L2 - FILL);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule